// File: doc/BRIEF.md
# Outbound Window and Bus-Master Address Decoder

This block sits beside a bridge between a CPU-side bus and a PCI bus and decides where addresses go. In the outbound direction it checks every CPU address against a set of 8 MiB windows laid out back to back from 0xF0000000. Slot `i` covers `0xF0000000 + i*0x800000` up to the next slot. A hit means the access is forwarded to PCI memory space at the same address. Slots 1 to 30 can be enabled one by one. Slot 0 and slot 31 never forward, whatever their enable bits hold. A two-bit mode field in a control word turns forwarding on or off for all slots at once.

In the inbound direction the block classifies each PCI bus-master address. It reports whether the address targets system RAM, the PCI window span or the CPU-local region, and passes the address through unchanged as the offset. Addresses that fall in none of the three regions raise a miss flag.

Both decodes are combinational from the address inputs. The outbound decode uses the register contents of the current cycle. A small write port loads the enable word and the control word, and a write changes the decode from the clock edge that captures it.

Top module: `obwin_decoder`

## Requirements
- R1: After reset the enable word and the control word are zero, so no CPU address gives an outbound hit.
- R2: With the mode field equal to binary 01, a CPU address in slot `i` (address bits [31:28] = 0xF, slot = bits [27:23]) for `i` in 1..30 with enable bit `i` set gives `fwdHit`=1 and `fwdWindow`=`i`. With enable bit `i` clear it gives `fwdHit`=0 and `fwdWindow`=0.
- R3: Slot 0 (0xF0000000–0xF07FFFFF) and slot 31 (0xFF800000–0xFFFFFFFF) never hit, even when enable bits 0 and 31 are set.
- R4: The mode field is control bits [8:7]. Any value other than 01 disables every slot. The other control bits have no effect on the decode.
- R5: `regSel`=0 writes the enable word and `regSel`=1 writes the control word when `regWrEn` is high at a rising clock edge. The outbound decode reflects the new value right after that edge.
- R6: A CPU address below 0xF0000000 never hits.
- R7: A bus-master address from 0x00000000 to 0xF07FFFFF gives `bmTarget`=1 (RAM), `bmMiss`=0 and `bmOffset` equal to the address.
- R8: A bus-master address from 0xF0800000 to 0xFF7FFFFF gives `bmTarget`=2 (PCI), `bmMiss`=0 and `bmOffset` equal to the address.
- R9: A bus-master address from 0xFFF00000 to 0xFFFFFFFE (a span of 0xFFFFF bytes) gives `bmTarget`=3 (CPU), `bmMiss`=0 and `bmOffset` equal to the address.
- R10: Any other bus-master address (0xFF800000–0xFFEFFFFF and 0xFFFFFFFF) gives `bmMiss`=1, `bmTarget`=0 and `bmOffset`=0.
- R11: The inbound decode does not depend on the enable word or the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the enable word, 1 selects the control word |
| regWrData | input | 32 | Write data |
| cpuAddr | input | 32 | Outbound CPU address |
| fwdHit | output | 1 | CPU address lies in an enabled forwarding slot |
| fwdWindow | output | 5 | Index of the hit slot, 0 when there is no hit |
| bmAddr | input | 32 | Inbound bus-master address |
| bmTarget | output | 2 | 0 miss, 1 RAM, 2 PCI, 3 CPU |
| bmMiss | output | 1 | Bus-master address is in no region |
| bmOffset | output | 32 | Translated address, 0 on a miss |

## Verification
Both address decodes have zero latency. The bench applies each address on a falling edge and samples the outputs a short delay later in the same low phase, well away from the next rising edge. A register write takes effect at the rising edge that sees `regWrEn`. The bench therefore updates its own model at that edge and checks the outbound decode only from the following falling edge. Random enable words, control words and addresses are mixed with directed cases at the slot edges and the inbound region boundaries.

// File: rtl/obwin_pkg.sv
package obwin_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_PCI  = 2'd2,
    TGT_CPU  = 2'd3
  } bmTarget_e;

  typedef struct packed {
    logic             loadEnable;
    logic             loadControl;
    logic [REG_W-1:0] data;
  } regStrobe_t;
endpackage

// File: rtl/obwin_ctrl.sv
module obwin_ctrl
  import obwin_pkg::*;
(
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] regWrData,
  output regStrobe_t       strb
);
  always_comb begin
    strb.loadEnable  = regWrEn && !regSel;
    strb.loadControl = regWrEn && regSel;
    strb.data        = regWrData;
  end
endmodule

// File: rtl/obwin_datapath.sv
module obwin_datapath
  import obwin_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          SLOT_BITS = 5,
  parameter int          WIN_SHIFT = 23,
  parameter logic [31:0] WIN_BASE  = 32'hF000_0000,
  parameter int          MODE_LSB  = 7,
  parameter logic [1:0]  MODE_ON   = 2'b01,
  parameter logic [31:0] CPU_BASE  = 32'hFFF0_0000,
  parameter logic [31:0] CPU_SPAN  = 32'h000F_FFFF
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strb,
  input  logic [ADDR_W-1:0]    cpuAddr,
  output logic                 fwdHit,
  output logic [SLOT_BITS-1:0] fwdWindow,
  input  logic [ADDR_W-1:0]    bmAddr,
  output logic [1:0]           bmTarget,
  output logic                 bmMiss,
  output logic [ADDR_W-1:0]    bmOffset
);
  localparam int NUM_SLOTS  = 1 << SLOT_BITS;
  localparam int REGION_LSB = WIN_SHIFT + SLOT_BITS;
  localparam logic [ADDR_W:0] SLOT_SIZE = (ADDR_W+1)'(1) << WIN_SHIFT;
  localparam logic [ADDR_W:0] PCI_LO    = {1'b0, WIN_BASE} + SLOT_SIZE;
  localparam logic [ADDR_W:0] PCI_END   = {1'b0, WIN_BASE} + SLOT_SIZE * (NUM_SLOTS - 1);
  localparam logic [ADDR_W:0] CPU_LO    = {1'b0, CPU_BASE};
  localparam logic [ADDR_W:0] CPU_END   = {1'b0, CPU_BASE} + {1'b0, CPU_SPAN};

  logic [REG_W-1:0] enableReg;
  logic [REG_W-1:0] controlReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableReg  <= '0;
      controlReg <= '0;
    end else begin
      if (strb.loadEnable)  enableReg  <= strb.data;
      if (strb.loadControl) controlReg <= strb.data;
    end
  end

  // Outbound decode
  logic                 modeOn;
  logic                 inRegion;
  logic [SLOT_BITS-1:0] slotIdx;
  logic [NUM_SLOTS-1:0] slotLive;
  logic [NUM_SLOTS-1:0] slotHit;

  assign modeOn   = controlReg[MODE_LSB+1:MODE_LSB] == MODE_ON;
  assign inRegion = cpuAddr[ADDR_W-1:REGION_LSB] == WIN_BASE[ADDR_W-1:REGION_LSB];
  assign slotIdx  = cpuAddr[REGION_LSB-1:WIN_SHIFT];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    if (s == 0 || s == NUM_SLOTS - 1) begin : g_fixed_off
      assign slotLive[s] = 1'b0;
    end else begin : g_gated
      assign slotLive[s] = modeOn && enableReg[s];
    end
    assign slotHit[s] = slotLive[s] && inRegion && (slotIdx == SLOT_BITS'(s));
  end

  always_comb begin
    fwdHit    = |slotHit;
    fwdWindow = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (slotHit[s]) fwdWindow = SLOT_BITS'(s);
    end
  end

  // Inbound decode
  logic [ADDR_W:0] bmWide;
  assign bmWide = {1'b0, bmAddr};

  always_comb begin
    bmTarget = TGT_NONE;
    if (bmWide < PCI_LO)                              bmTarget = TGT_RAM;
    else if (bmWide < PCI_END)                        bmTarget = TGT_PCI;
    else if (bmWide >= CPU_LO && bmWide < CPU_END)    bmTarget = TGT_CPU;
    bmMiss   = bmTarget == TGT_NONE;
    bmOffset = bmMiss ? '0 : bmAddr;
  end

  // R3: the edge slots never forward
  a_r3_edge_slots: assert property (@(posedge clk) disable iff (!rstN)
    fwdHit |-> (fwdWindow != '0 && fwdWindow != SLOT_BITS'(NUM_SLOTS - 1)));
  // R2: the reported slot matches the address
  a_r2_window_matches: assert property (@(posedge clk) disable iff (!rstN)
    fwdHit |-> (cpuAddr[REGION_LSB-1:WIN_SHIFT] == fwdWindow));
  // R4: a hit needs the mode field to be on
  a_r4_mode_gate: assert property (@(posedge clk) disable iff (!rstN)
    fwdHit |-> controlReg[MODE_LSB+1:MODE_LSB] == MODE_ON);
  // R5: writes land at the next edge
  a_r5_enable_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadEnable |=> enableReg == $past(strb.data));
  a_r5_control_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadControl |=> controlReg == $past(strb.data));
  // R10: a miss carries no offset
  a_r10_miss_clean: assert property (@(posedge clk) disable iff (!rstN)
    bmMiss |-> (bmOffset == '0 && bmTarget == TGT_NONE));
  // R6: nothing below the window region hits
  a_r6_low_addr: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr < WIN_BASE) |-> !fwdHit);
endmodule

// File: rtl/obwin_decoder.sv
module obwin_decoder
  import obwin_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regSel,
  input  logic [31:0] regWrData,
  input  logic [31:0] cpuAddr,
  output logic        fwdHit,
  output logic [4:0]  fwdWindow,
  input  logic [31:0] bmAddr,
  output logic [1:0]  bmTarget,
  output logic        bmMiss,
  output logic [31:0] bmOffset
);
  regStrobe_t strb;

  obwin_ctrl u_ctrl (
    .regWrEn  (regWrEn),
    .regSel   (regSel),
    .regWrData(regWrData),
    .strb     (strb)
  );

  obwin_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cpuAddr  (cpuAddr),
    .fwdHit   (fwdHit),
    .fwdWindow(fwdWindow),
    .bmAddr   (bmAddr),
    .bmTarget (bmTarget),
    .bmMiss   (bmMiss),
    .bmOffset (bmOffset)
  );
endmodule

// File: tb/sim_obwin_decoder.sv
module sim_obwin_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] cpuAddr = '0;
  logic [31:0] bmAddr = '0;
  logic        fwdHit;
  logic [4:0]  fwdWindow;
  logic [1:0]  bmTarget;
  logic        bmMiss;
  logic [31:0] bmOffset;

  int checks = 0;
  int failures = 0;
  logic [31:0] mEnable = '0;
  logic [31:0] mControl = '0;

  always #5 clk = ~clk;

  obwin_decoder u0 (.*);

  function automatic logic [5:0] expFwd(input logic [31:0] a, input logic [31:0] en,
                                        input logic [31:0] ctl);
    int slot;
    slot = int'(a[27:23]);
    if (ctl[8:7] == 2'b01 && a[31:28] == 4'hF && slot >= 1 && slot <= 30 && en[slot])
      return {1'b1, a[27:23]};
    return 6'd0;
  endfunction

  function automatic logic [1:0] expTgt(input logic [31:0] a);
    if (a <= 32'hF07F_FFFF) return 2'd1;
    if (a <= 32'hFF7F_FFFF) return 2'd2;
    if (a >= 32'hFFF0_0000 && a <= 32'hFFFF_FFFE) return 2'd3;
    return 2'd0;
  endfunction

  task automatic chkFwd(input string req, input logic [31:0] a);
    logic [5:0] e;
    @(negedge clk);
    cpuAddr = a;
    #1;
    e = expFwd(a, mEnable, mControl);
    checks++;
    if ({fwdHit, fwdWindow} !== e) begin
      failures++;
      $display("FAIL %s addr=%h actual hit=%0d win=%0d expected hit=%0d win=%0d",
               req, a, fwdHit, fwdWindow, e[5], e[4:0]);
    end
  endtask

  task automatic chkBm(input string req, input logic [31:0] a);
    logic [1:0] t;
    logic [31:0] o;
    @(negedge clk);
    bmAddr = a;
    #1;
    t = expTgt(a);
    o = (t == 2'd0) ? 32'd0 : a;
    checks++;
    if (bmTarget !== t || bmMiss !== (t == 2'd0) || bmOffset !== o) begin
      failures++;
      $display("FAIL %s addr=%h actual tgt=%0d miss=%0d off=%h expected tgt=%0d miss=%0d off=%h",
               req, a, bmTarget, bmMiss, bmOffset, t, (t == 2'd0), o);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(posedge clk);
    if (sel) mControl = d; else mEnable = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1: reset state
    chkFwd("R1", 32'hF080_0000);
    chkFwd("R1", 32'hF800_0000);
    // R5: write enables and mode; R2 hits
    wr(1'b0, 32'hFFFF_FFFF);
    chkFwd("R4", 32'hF100_0000);
    wr(1'b1, 32'h0000_0080);
    chkFwd("R5", 32'hF100_0000);
    chkFwd("R2", 32'hF080_0000);
    chkFwd("R2", 32'hFF7F_FFFF);
    // R3: edge slots
    chkFwd("R3", 32'hF000_0000);
    chkFwd("R3", 32'hF07F_FFFF);
    chkFwd("R3", 32'hFF80_0000);
    chkFwd("R3", 32'hFFFF_FFFF);
    // R6: below region
    chkFwd("R6", 32'hEFFF_FFFF);
    chkFwd("R6", 32'h0080_0000);
    // R4: other mode values, other control bits ignored
    wr(1'b1, 32'h0000_0180);
    chkFwd("R4", 32'hF100_0000);
    wr(1'b1, 32'h0000_0100);
    chkFwd("R4", 32'hF100_0000);
    wr(1'b1, 32'hFFFF_FE7F);
    chkFwd("R4", 32'hF100_0000);
    wr(1'b1, 32'h0000_00FF);
    chkFwd("R4", 32'hF100_0000);
    // R2: single enable bit
    wr(1'b0, 32'h0000_0004);
    chkFwd("R2", 32'hF100_0000);
    chkFwd("R2", 32'hF180_0000);
    // R7..R10 boundaries
    chkBm("R7", 32'h0000_0000);
    chkBm("R7", 32'hF07F_FFFF);
    chkBm("R8", 32'hF080_0000);
    chkBm("R8", 32'hFF7F_FFFF);
    chkBm("R10", 32'hFF80_0000);
    chkBm("R10", 32'hFFEF_FFFF);
    chkBm("R9", 32'hFFF0_0000);
    chkBm("R9", 32'hFFFF_FFFE);
    chkBm("R10", 32'hFFFF_FFFF);
    // R11: inbound decode unchanged with registers cleared
    wr(1'b0, 32'h0);
    wr(1'b1, 32'h0);
    chkBm("R11", 32'hF080_0000);
    chkBm("R11", 32'hFFF0_1000);
    // Random mix
    for (int k = 0; k < 300; k++) begin
      logic [31:0] a;
      if ($urandom_range(0, 3) == 0) wr(1'b0, $urandom);
      if ($urandom_range(0, 5) == 0)
        wr(1'b1, ($urandom & 32'hFFFF_FE7F) |
                 ($urandom_range(0, 1) ? 32'h80 : ({30'd0, 2'($urandom)} << 7)));
      a = $urandom;
      if ($urandom_range(0, 1) == 1) a[31:28] = 4'hF;
      chkFwd("R2", a);
      a = $urandom;
      if ($urandom_range(0, 1) == 1) a[31:24] = 8'hFF;
      chkBm("R8", a);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule